// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block gathers a wide vector of level-sensitive interrupt sources and folds them into a smaller number of request lines for a parent interrupt controller. Sources are taken eight at a time: each eight-source group has one output line. That line is high for as long as at least one source in the group is active and enabled. Nothing is latched. When the sources drop, the line drops.

Software controls the block through a synchronous register port. Each register bank is 32 bits wide and holds four groups, packed one byte per group. Group `g` uses bits `8*(g%4)+7 .. 8*(g%4)` of bank `g/4`, and bank `b` starts at byte address `0x10*b`. Inside a bank there are three registers:

- A write-one-to-set enable port. Reading this address returns the enable mask, so software can save the mask and restore it later.
- A write-one-to-clear enable port.
- A read-only status register. It shows which sources are both active and enabled.

Sources pass through a two-stage synchronizer before they are masked. The group outputs are registered.

Top module: `irqc_top`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and every status register reads 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits written with 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits written with 0 keep their value.
- R4: A read of bank offset 0x0 returns that bank's current enable mask.
- R5: A read of bank offset 0xC returns, for each bit, the synchronized source level AND its enable bit.
- R6: Source `i` belongs to group `i/8`. Its enable and status bit is bit `i%32` of the bank at byte address `0x10*(i/32)`.
- R7: Group output `g` is the OR of the eight status bits of group `g`. It follows the level of its sources with no latching: it falls again once they are released.
- R8: A source change is seen on the group output exactly three clock edges later. An enable write is seen on the group output one edge after the edge that performs the write.
- R9: The following writes are ignored and change no enable bit:
  - writes to offset 0xC;
  - writes to offset 0x8;
  - writes to any offset that is not one of 0x0, 0x4, 0xC;
  - writes to any bank index at or beyond the number of banks.
- R10: A read of an undefined offset, or of a bank that does not exist, returns 0. In a last bank holding fewer than four groups, the enable bits above the implemented groups always read 0.
- R11: Read data is registered. It appears on `reg_rdata_o` after the clock edge at which the address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | ADDR_W | Byte address; upper bits select the bank, low four bits the register |
| reg_wr_i | input | 1 | Write strobe for the current address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data for the address of the previous cycle |
| irq_src_i | input | 8*NUM_GROUPS | Level-sensitive interrupt sources |
| grp_irq_o | output | NUM_GROUPS | One registered request line per group |

## Verification
A corrupted enable bit appears in two places:

- on the enable readback one cycle after the read is issued;
- on the affected group line one edge after the faulty write.

So a set or clear that touches the wrong lane shows up within two cycles. A wrong synchronizer depth, or a group wired to the wrong source byte, shows up on the output lines three edges after a single source is raised. The bench therefore walks a lone active source across every input position and checks the exact edge at which exactly one line responds. A source that sticks would keep its line high after release, and the release check three edges later catches it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W   = 32;
    localparam int LANE_W  = 8;
    localparam int LANES_PER_BANK = REG_W / LANE_W;

    localparam logic [3:0] OFF_EN_SET = 4'h0;
    localparam logic [3:0] OFF_EN_CLR = 4'h4;
    localparam logic [3:0] OFF_STATUS = 4'hC;

    typedef enum logic [1:0] {
        WOP_NONE = 2'd0,
        WOP_SET  = 2'd1,
        WOP_CLR  = 2'd2
    } wop_e;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_EN   = 2'd1,
        RSEL_STAT = 2'd2
    } rsel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5,
    localparam int BANK_W   = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              hit_o,
    output wop_e              wop_o,
    output rsel_e             rsel_o
);
    logic [3:0] offset;

    always_comb begin
        bank_o = addr_i[ADDR_W-1:4];
        offset = addr_i[3:0];
        hit_o  = (32'(bank_o) < NUM_BANKS);

        wop_o = WOP_NONE;
        if (wr_i && hit_o) begin
            if (offset == OFF_EN_SET) begin
                wop_o = WOP_SET;
            end else if (offset == OFF_EN_CLR) begin
                wop_o = WOP_CLR;
            end
        end

        rsel_o = RSEL_NONE;
        if (hit_o) begin
            if (offset == OFF_EN_SET) begin
                rsel_o = RSEL_EN;
            end else if (offset == OFF_STATUS) begin
                rsel_o = RSEL_STAT;
            end
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  wop_e             wop_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] lvl_i,
    output logic [REG_W-1:0] en_o,
    output logic [REG_W-1:0] stat_o,
    output logic [LANES-1:0] any_o
);
    localparam int IMPL_BITS = LANES * LANE_W;
    localparam logic [REG_W-1:0] IMPL_MASK =
        (IMPL_BITS >= REG_W) ? {REG_W{1'b1}} : ((REG_W'(1) << IMPL_BITS) - REG_W'(1));

    typedef struct packed {
        logic [REG_W-1:0] en;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [REG_W-1:0] wmask;

    always_comb begin
        st_d  = st_q;
        wmask = wdata_i & IMPL_MASK;
        case (wop_i)
            WOP_SET: st_d.en = st_q.en | wmask;
            WOP_CLR: st_d.en = st_q.en & ~wmask;
            default: st_d.en = st_q.en;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign stat_o = lvl_i & st_q.en & IMPL_MASK;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign any_o[l] = |stat_o[l*LANE_W +: LANE_W];
    end

    // R2: set port leaves the written ones set
    a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wop_i == WOP_SET) |=>
            ((en_o & $past(wdata_i & IMPL_MASK)) == $past(wdata_i & IMPL_MASK)));

    // R2: set port never drops a bit
    a_r2_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wop_i == WOP_SET) |=> ((en_o & $past(en_o)) == $past(en_o)));

    // R3: clear port leaves the written ones cleared
    a_r3_clear_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wop_i == WOP_CLR) |=> ((en_o & $past(wdata_i)) == '0));

    // R3: clear port never raises a bit
    a_r3_clear_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wop_i == WOP_CLR) |=> ((en_o | $past(en_o)) == $past(en_o)));

    // R9: no decoded operation, no change
    a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wop_i == WOP_NONE) |=> $stable(en_o));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_IN    = NUM_GROUPS * LANE_W,
    localparam int NUM_BANKS = (NUM_GROUPS + LANES_PER_BANK - 1) / LANES_PER_BANK,
    localparam int PAD_W     = NUM_BANKS * REG_W,
    localparam int BANK_W    = ADDR_W - 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    input  logic [NUM_IN-1:0]     irq_src_i,
    output logic [NUM_GROUPS-1:0] grp_irq_o
);
    typedef struct packed {
        logic [NUM_GROUPS-1:0] grp;
        logic [REG_W-1:0]      rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_IN-1:0]     src_sync;
    logic [PAD_W-1:0]      lvl_pad;
    logic [BANK_W-1:0]     dec_bank;
    logic                  dec_hit;
    wop_e                  dec_wop;
    rsel_e                 dec_rsel;
    logic [NUM_GROUPS-1:0] any_flat;
    logic [REG_W-1:0]      bank_en   [NUM_BANKS];
    logic [REG_W-1:0]      bank_stat [NUM_BANKS];

    irqc_sync #(.WIDTH(NUM_IN)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_src_i),
        .sync_o  (src_sync)
    );

    assign lvl_pad = PAD_W'(src_sync);

    irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
        .addr_i (reg_addr_i),
        .wr_i   (reg_wr_i),
        .bank_o (dec_bank),
        .hit_o  (dec_hit),
        .wop_o  (dec_wop),
        .rsel_o (dec_rsel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LANES_B = ((NUM_GROUPS - b * LANES_PER_BANK) < LANES_PER_BANK)
                                 ? (NUM_GROUPS - b * LANES_PER_BANK) : LANES_PER_BANK;
        wop_e bank_wop;

        assign bank_wop = (dec_hit && (dec_bank == BANK_W'(b))) ? dec_wop : WOP_NONE;

        irqc_bank #(.LANES(LANES_B)) u_bank (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wop_i   (bank_wop),
            .wdata_i (reg_wdata_i),
            .lvl_i   (lvl_pad[b*REG_W +: REG_W]),
            .en_o    (bank_en[b]),
            .stat_o  (bank_stat[b]),
            .any_o   (any_flat[b*LANES_PER_BANK +: LANES_B])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.grp   = any_flat;
        st_d.rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_bank == BANK_W'(b)) begin
                if (dec_rsel == RSEL_EN) begin
                    st_d.rdata = bank_en[b];
                end else if (dec_rsel == RSEL_STAT) begin
                    st_d.rdata = bank_stat[b];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_irq_o   = st_q.grp;
    assign reg_rdata_o = st_q.rdata;

    // R10: an address the decoder rejects reads back as zero
    a_r10_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_rsel == RSEL_NONE) |=> (reg_rdata_o == '0));

    // R7: a group line is only raised by a pending group in the prior cycle
    a_r7_line_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_flat == '0) |=> (grp_irq_o == '0));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    localparam int NG   = 6;
    localparam int AW   = 6;
    localparam int NIN  = NG * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NIN-1:0]  src = '0;
    logic [NG-1:0]   grp;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_en [2];

    always #5 clk = ~clk;

    irqc_top #(.NUM_GROUPS(NG), .ADDR_W(AW)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_src_i   (src),
        .grp_irq_o   (grp)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; addr = '0;
    endtask

    task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [NG-1:0] exp_grp(input logic [NIN-1:0] s);
        logic [63:0] en_full;
        logic [NG-1:0] r;
        en_full = {m_en[1], m_en[0]};
        for (int g = 0; g < NG; g++) r[g] = |(s[g*8 +: 8] & en_full[g*8 +: 8]);
        return r;
    endfunction

    function automatic logic [31:0] exp_stat(input logic [NIN-1:0] s, input int b);
        logic [63:0] sp;
        sp = 64'(s);
        return sp[b*32 +: 32] & m_en[b];
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NIN-1:0] p;
        m_en[0] = '0; m_en[1] = '0;
        edges(3);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check(grp == '0, "R1 outputs", 64'(grp), 0);
        reg_rd(6'h00, d); check(d == 0, "R1 enable bank0", d, 0);
        reg_rd(6'h1C, d); check(d == 0, "R1 status bank1", d, 0);

        // R2, R4: set port and readback
        reg_wr(6'h00, 32'hA5A5_A5A5); m_en[0] = 32'hA5A5_A5A5;
        reg_rd(6'h00, d); check(d == m_en[0], "R2 R4 set readback", d, m_en[0]);
        reg_wr(6'h00, 32'h0F0F_0000); m_en[0] |= 32'h0F0F_0000;
        reg_rd(6'h00, d); check(d == m_en[0], "R2 set keeps prior", d, m_en[0]);
        // R3: clear port
        reg_wr(6'h04, 32'h00FF_00FF); m_en[0] &= ~32'h00FF_00FF;
        reg_rd(6'h00, d); check(d == m_en[0], "R3 clear", d, m_en[0]);
        // R10: partial bank top bits stay zero
        reg_wr(6'h10, 32'hFFFF_FFFF); m_en[1] = 32'h0000_FFFF;
        reg_rd(6'h10, d); check(d == m_en[1], "R10 partial bank", d, m_en[1]);
        reg_wr(6'h14, 32'h0000_00F0); m_en[1] &= ~32'h0000_00F0;
        reg_rd(6'h10, d); check(d == m_en[1], "R3 clear bank1", d, m_en[1]);

        // R9: ignored writes
        reg_wr(6'h0C, 32'hFFFF_FFFF);
        reg_wr(6'h08, 32'hFFFF_FFFF);
        reg_wr(6'h01, 32'hFFFF_FFFF);
        reg_wr(6'h24, 32'hFFFF_FFFF);
        reg_wr(6'h20, 32'hFFFF_FFFF);
        reg_wr(6'h1C, 32'hFFFF_FFFF);
        reg_rd(6'h00, d); check(d == m_en[0], "R9 bank0 untouched", d, m_en[0]);
        reg_rd(6'h10, d); check(d == m_en[1], "R9 bank1 untouched", d, m_en[1]);
        // R10: undefined reads
        reg_rd(6'h08, d); check(d == 0, "R10 offset 0x8", d, 0);
        reg_rd(6'h04, d); check(d == 0, "R10 offset 0x4", d, 0);
        reg_rd(6'h20, d); check(d == 0, "R10 missing bank", d, 0);
        // R11: read data follows presented address one edge later
        @(negedge clk) addr = 6'h00;
        @(posedge clk);
        @(negedge clk) addr = 6'h08;
        check(rdata == m_en[0], "R11 registered read", rdata, m_en[0]);

        // R6, R7, R8: walk a single source with everything enabled
        reg_wr(6'h00, 32'hFFFF_FFFF); m_en[0] = 32'hFFFF_FFFF;
        reg_wr(6'h10, 32'hFFFF_FFFF); m_en[1] = 32'h0000_FFFF;
        for (int i = 0; i < NIN; i++) begin
            @(negedge clk) src = NIN'(1) << i;
            edges(2);
            check(grp == '0, "R8 not before third edge", 64'(grp), 0);
            edges(1);
            check(grp == (NG'(1) << (i / 8)), "R6 R8 group line", 64'(grp), 64'(1) << (i / 8));
            reg_rd(AW'((i / 32) * 16 + 12), d);
            check(d == (32'd1 << (i % 32)), "R5 R6 status bit", d, 32'd1 << (i % 32));
            @(negedge clk) src = '0;
            edges(3);
            check(grp == '0, "R7 released", 64'(grp), 0);
        end

        // R5, R7: masked patterns
        m_en[0] = 32'h3C00_FF81; m_en[1] = 32'h0000_0F10;
        reg_wr(6'h04, 32'hFFFF_FFFF); reg_wr(6'h00, m_en[0]);
        reg_wr(6'h14, 32'hFFFF_FFFF); reg_wr(6'h10, m_en[1]);
        for (int k = 0; k < 16; k++) begin
            p = {16'(k * 16'h3C5B ^ 16'h0009), 32'(k * 32'h9E37_79B9 + 32'h0123_4567)};
            @(negedge clk) src = p;
            edges(3);
            check(grp == exp_grp(p), "R7 masked OR", 64'(grp), 64'(exp_grp(p)));
            reg_rd(6'h0C, d); check(d == exp_stat(p, 0), "R5 status bank0", d, exp_stat(p, 0));
            reg_rd(6'h1C, d); check(d == exp_stat(p, 1), "R5 status bank1", d, exp_stat(p, 1));
        end

        // R8: enable write latency with a held source
        @(negedge clk) src = NIN'(1) << 40;
        reg_wr(6'h14, 32'h0000_0100); m_en[1] &= ~32'h0000_0100;
        edges(3);
        check(grp[5] == 1'b0, "R8 disabled line low", 64'(grp), 0);
        @(negedge clk) addr = 6'h10; wdata = 32'h0000_0100; wr = 1'b1;
        @(posedge clk);
        @(negedge clk) wr = 1'b0;
        check(grp[5] == 1'b0, "R8 line not at write edge", 64'(grp), 0);
        edges(1);
        check(grp[5] == 1'b1, "R8 line one edge after write", 64'(grp[5]), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule